// File: doc/BRIEF.md
# Quad Double-Buffered Converter Code Register Front-End

This block holds the digital state of a four-channel, 12-bit serial-input converter. A 14-bit word arrives one bit at a time. Its two top bits name one of four channels and its low twelve bits carry the code. Each channel keeps that code in two stages: a staging register and an output register. New codes can be placed in the staging registers one channel at a time. All four outputs then move together when the output-load control goes low.

All control pins are active-low levels. The shift register moves on each rising edge of the OR of the select and serial-clock pins. A staging register follows the shift register while its load control is low and it is addressed. The output registers follow the staging registers while the output-load control is low. A clear pin forces every staging and output register to zero-scale or mid-scale, as a select pin chooses. The clear does not touch the shift register.

All pins are sampled on the rising edge of a fast system clock, and the level-transparent paths are modelled as one-cycle register stages.

Top module: `quad_code_frontend`

## Requirements
- R1: The shift register advances by one bit on each rising edge of (cs_n OR sclk) seen between two system clock samples. The new bit is sdi, entering at bit 0, so the word is sent most significant bit first. Bits [13:12] form the address and bits [11:0] the code.
- R2: Address 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel i drives dac_code[12*i+11:12*i], with A at bits [11:0].
- R3: While ld_stage_n is low, the addressed staging register takes the shift-register code one clock later. The other three staging registers keep their values.
- R4: While ld_out_n is low, every output register takes its staging register's value one clock later. While ld_out_n is high, the outputs hold.
- R5: While clr_n is low, all staging and output registers are set to 12'h800 when clr_mid is 1, or to 12'h000 when it is 0. This overrides both load controls.
- R6: After clr_n rises with both load controls high, all outputs keep the clear value.
- R7: Holding clr_n low leaves the shift register contents unchanged.
- R8: Raising cs_n while sclk is low causes one extra shift, which moves both the address and the code.
- R9: If bits are shifted while ld_stage_n is low, each intermediate address selects a staging register. That register takes the intermediate code.
- R10: While rst is high, the shift register and all registers clear to zero, and the edge detector is primed so that no shift follows reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, ORed with sclk to form the shift strobe |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data, most significant bit first |
| ld_stage_n | input | 1 | Active-low: addressed staging register follows the shift register |
| ld_out_n | input | 1 | Active-low: all output registers follow the staging registers |
| clr_n | input | 1 | Active-low clear of staging and output registers |
| clr_mid | input | 1 | Clear value select: 1 = 12'h800, 0 = 12'h000 |
| dac_code | output | 48 | Four 12-bit output codes, channel A at bits [11:0] |

## Verification
The staging registers have no port of their own. An error in them therefore shows only at dac_code, one clock after ld_out_n goes low, as a wrong code on a single channel. An error in the shift register, such as a lost or extra strobe, usually shows up as a wrong address. The code then lands on a different channel, and two lanes change at the next output load. Errors in the clear logic show at once on all four lanes while clr_n is low. Errors in retention after clear show when the outputs drift away from the clear value after release.

// File: rtl/qcf_pkg.sv
package qcf_pkg;
    parameter int CODE_W = 12;
    parameter int NUM_CH = 4;
    localparam int ADDR_W = $clog2(NUM_CH);
    localparam int WORD_W = ADDR_W + CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef code_t [NUM_CH-1:0] bank_t;

    typedef struct packed {
        addr_t addr;
        code_t code;
    } word_t;

    function automatic code_t clear_code(input logic mid);
        code_t c;
        c = '0;
        c[CODE_W-1] = mid;
        return c;
    endfunction
endpackage

// File: rtl/qcf_shifter.sv
module qcf_shifter
    import qcf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  sclk,
    input  logic  sdi,
    output word_t word
);
    logic              strobe_lvl;
    logic              strobe_prev;
    logic              strobe_edge;
    logic [WORD_W-1:0] sr_q;

    assign strobe_lvl  = cs_n | sclk;
    assign strobe_edge = strobe_lvl & ~strobe_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_prev <= 1'b1;
            sr_q        <= '0;
        end else begin
            strobe_prev <= strobe_lvl;
            if (strobe_edge) begin
                sr_q <= {sr_q[WORD_W-2:0], sdi};
            end
        end
    end

    assign word = word_t'(sr_q);

    AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cs_n | sclk) |=> $stable(sr_q)); // R1
    AST_SR_FRESH_BIT: assert property (@(posedge clk) disable iff (rst)
        (strobe_lvl && !strobe_prev) |=> (sr_q[0] == $past(sdi))); // R8
endmodule

// File: rtl/qcf_stage_bank.sv
module qcf_stage_bank
    import qcf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_stage_n,
    input  logic  clr_n,
    input  logic  clr_mid,
    input  word_t word,
    output bank_t stage
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = !ld_stage_n && (word.addr == addr_t'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                stage[i] <= '0;
            end else if (!clr_n) begin
                stage[i] <= clear_code(clr_mid);
            end else if (hit) begin
                stage[i] <= word.code;
            end
        end

        AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (rst)
            (clr_n && (ld_stage_n || word.addr != addr_t'(i))) |=> $stable(stage[i])); // R3
        AST_STAGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
            !clr_n |=> (stage[i] == ($past(clr_mid) ? code_t'(1 << (CODE_W-1)) : code_t'(0)))); // R5
    end
endmodule

// File: rtl/qcf_out_bank.sv
module qcf_out_bank
    import qcf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_out_n,
    input  logic  clr_n,
    input  logic  clr_mid,
    input  bank_t stage,
    output bank_t outq
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                outq[i] <= '0;
            end else if (!clr_n) begin
                outq[i] <= clear_code(clr_mid);
            end else if (!ld_out_n) begin
                outq[i] <= stage[i];
            end
        end

        AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
            (clr_n && ld_out_n) |=> $stable(outq[i])); // R4
        AST_OUT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
            (clr_n && !ld_out_n) |=> (outq[i] == $past(stage[i]))); // R4
        AST_OUT_CLEAR: assert property (@(posedge clk) disable iff (rst)
            !clr_n |=> (outq[i] == ($past(clr_mid) ? code_t'(1 << (CODE_W-1)) : code_t'(0)))); // R5
    end
endmodule

// File: rtl/quad_code_frontend.sv
module quad_code_frontend
    import qcf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_n,
    input  logic                     sclk,
    input  logic                     sdi,
    input  logic                     ld_stage_n,
    input  logic                     ld_out_n,
    input  logic                     clr_n,
    input  logic                     clr_mid,
    output logic [NUM_CH*CODE_W-1:0] dac_code
);
    word_t word;
    bank_t stage;
    bank_t outq;

    qcf_shifter u_shift (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .sdi  (sdi),
        .word (word)
    );

    qcf_stage_bank u_stage (
        .clk        (clk),
        .rst        (rst),
        .ld_stage_n (ld_stage_n),
        .clr_n      (clr_n),
        .clr_mid    (clr_mid),
        .word       (word),
        .stage      (stage)
    );

    qcf_out_bank u_out (
        .clk      (clk),
        .rst      (rst),
        .ld_out_n (ld_out_n),
        .clr_n    (clr_n),
        .clr_mid  (clr_mid),
        .stage    (stage),
        .outq     (outq)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_pack
        assign dac_code[i*CODE_W +: CODE_W] = outq[i];
    end

    AST_SHIFT_KEPT_IN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && cs_n && sclk) |=> $stable(word)); // R7
endmodule

// File: tb/tb_quad_code_frontend.sv
module tb_quad_code_frontend;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
    logic        ld_stage_n = 1'b1, ld_out_n = 1'b1;
    logic        clr_n = 1'b1, clr_mid = 1'b0;
    logic [47:0] dac_code;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [13:0] m_sr = '0;
    logic [11:0] m_stage [4];
    logic [11:0] m_out [4];

    always #2 clk = ~clk;

    quad_code_frontend dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .ld_stage_n(ld_stage_n), .ld_out_n(ld_out_n),
        .clr_n(clr_n), .clr_mid(clr_mid), .dac_code(dac_code)
    );

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        if (!clr_n) begin
            for (int i = 0; i < 4; i++) begin
                m_stage[i] = clr_mid ? 12'h800 : 12'h000;
                m_out[i]   = m_stage[i];
            end
        end else begin
            if (!ld_stage_n) m_stage[m_sr[13:12]] = m_sr[11:0];
            if (!ld_out_n) for (int i = 0; i < 4; i++) m_out[i] = m_stage[i];
        end
    endtask

    task automatic chk(input string req, input int ch, input logic [11:0] exp);
        logic [11:0] act;
        act = dac_code[ch*12 +: 12];
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < 4; i++) chk(req, i, m_out[i]);
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk); sclk = 1'b0; sdi = b;
        settle(2);
        sclk = 1'b1;
        m_sr = {m_sr[12:0], b};
        settle(3);
    endtask

    task automatic send_word(input logic [1:0] a, input logic [11:0] d);
        logic [13:0] w;
        w = {a, d};
        @(negedge clk); cs_n = 1'b0;
        for (int k = 13; k >= 0; k--) shift_bit(w[k]);
        @(negedge clk); cs_n = 1'b1;
        settle(2);
    endtask

    task automatic pulse_stage();
        @(negedge clk); ld_stage_n = 1'b0; settle(3);
        ld_stage_n = 1'b1; settle(3);
    endtask

    task automatic pulse_out();
        @(negedge clk); ld_out_n = 1'b0; settle(3);
        ld_out_n = 1'b1; settle(3);
    endtask

    task automatic t_reset_state();
        for (int i = 0; i < 4; i++) begin m_stage[i] = '0; m_out[i] = '0; end
        chk_all("R10 reset state");
    endtask

    task automatic t_clear();
        @(negedge clk); clr_mid = 1'b1; clr_n = 1'b0; settle(3);
        chk_all("R5 clear mid");
        clr_n = 1'b1; settle(4);
        chk_all("R6 retain after clear");
        @(negedge clk); clr_mid = 1'b0; clr_n = 1'b0; settle(3);
        chk_all("R5 clear zero");
        clr_n = 1'b1; settle(3);
    endtask

    task automatic t_double_buffer();
        send_word(2'd0, 12'h111); pulse_stage();
        send_word(2'd1, 12'h2A2); pulse_stage();
        send_word(2'd2, 12'h3C3); pulse_stage();
        send_word(2'd3, 12'hFE4); pulse_stage();
        chk_all("R4 outputs hold while staging");
        pulse_out();
        chk(0, 0, 12'h111);
        chk("R2 map B", 1, 12'h2A2);
        chk("R2 map C", 2, 12'h3C3);
        chk("R2 map D", 3, 12'hFE4);
    endtask

    task automatic t_transparent();
        @(negedge clk); ld_out_n = 1'b0; settle(3);
        send_word(2'd1, 12'hABC); pulse_stage();
        chk("R3 selected B", 1, 12'hABC);
        chk("R3 unselected A", 0, 12'h111);
        chk("R3 unselected C", 2, 12'h3C3);
        chk("R3 unselected D", 3, 12'hFE4);
        ld_out_n = 1'b1; settle(3);
    endtask

    task automatic t_clear_keeps_shift();
        send_word(2'd2, 12'h5A5);
        @(negedge clk); clr_mid = 1'b1; clr_n = 1'b0; settle(3);
        clr_n = 1'b1; settle(3);
        chk_all("R6 outputs at clear value");
        pulse_stage(); pulse_out();
        chk("R7 shift kept through clear", 2, 12'h5A5);
        chk("R7 others at clear", 0, 12'h800);
    endtask

    task automatic t_extra_shift();
        logic [13:0] w;
        w = {2'd1, 12'h800};
        @(negedge clk); cs_n = 1'b0;
        for (int k = 13; k >= 0; k--) shift_bit(w[k]);
        @(negedge clk); sclk = 1'b0; sdi = 1'b0; settle(2);
        cs_n = 1'b1; m_sr = {m_sr[12:0], 1'b0}; settle(3);
        sclk = 1'b1; settle(2);
        pulse_stage(); pulse_out();
        chk("R8 spurious shift hits D", 3, 12'h000);
        chk("R8 B untouched", 1, 12'h800);
        chk("R8 model D", 3, m_out[3]);
    endtask

    task automatic t_flow_through();
        @(negedge clk); ld_stage_n = 1'b0; settle(1);
        send_word(2'd0, 12'h3C3);
        ld_stage_n = 1'b1; settle(3);
        pulse_out();
        chk_all("R9 flow-through corruption");
        chk("R9 final A", 0, 12'h3C3);
        chk("R1 shift contents", 0, m_sr[11:0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle(2);
        t_reset_state();
        t_clear();
        t_double_buffer();
        t_transparent();
        t_clear_keeps_shift();
        t_extra_shift();
        t_flow_through();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule